// File: doc/BRIEF.md
# Dual-Issue Register File with Special Registers

This block is the architectural register file of a two-wide pipeline. Two instructions, called slot 0 (earlier in program order) and slot 1 (later), reach the register-read stage together. Each slot has two read ports, and a single write stage at the end of the pipe presents up to two results per clock.

Two register numbers have fixed meanings. Register 0 reads as zero and is never written, so a destination number of 0 means "no result". Register 1 has no storage. Reading it returns the 16-bit fetch address that travels with the reading instruction, zero-extended to 32 bits. Because each slot brings its own address, the two slots can see different values for register 1 in the same cycle. Writes aimed at register 1 are dropped in the same way as writes to register 0.

Reads are combinational. A write becomes visible on the clock edge that commits it, so a read of a register that is being written in the same cycle returns the old contents. Supplying the new value early is left to the forwarding network outside this block. When both slots name the same stored register in one cycle, slot 1 is later in program order and its value is the one kept.

The register cells have no state machine. Each register number is put into one of three read classes (ZERO, PCVAL, STORED). A per-register write selector chooses among three transitions: HOLD (keep the contents), TAKE0 (load slot 0 data) and TAKE1 (load slot 1 data, which takes priority over slot 0).

Top module: `dual_rf`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every stored register (numbers 2 to NREG-1) is cleared to zero. After reset, all of them read 0 on every read port.
- R2: Any read port addressed with register 0 returns 0, whatever has been written.
- R3: A read port addressed with register 1 returns {16'b0, pc} of its own slot: `pc0` for `rd0_a`/`rd0_b` and `pc1` for `rd1_a`/`rd1_b`.
- R4: A write from either port to a register numbered 2 or above becomes visible on all four read ports from the clock edge that commits it.
- R5: A write with destination 0 changes no register. A stored register that receives no write keeps its value.
- R6: A write with destination 1 changes no register, and register 1 reads still return the slot's PC.
- R7: When both write ports name the same register (2 or above) in one cycle, the slot 1 data is stored.
- R8: Two writes to different registers in the same cycle are both stored.
- R9: A read of a register that is being written in the same cycle returns the value held before that write.
- R10: Reads have zero latency: each read data output follows its address and `pc` input within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the stored registers |
| pc0 | input | PCW | Fetch address of the slot 0 instruction |
| pc1 | input | PCW | Fetch address of the slot 1 instruction |
| ra0_a | input | AW | Slot 0 first read address |
| ra0_b | input | AW | Slot 0 second read address |
| ra1_a | input | AW | Slot 1 first read address |
| ra1_b | input | AW | Slot 1 second read address |
| rd0_a | output | XLEN | Slot 0 first read data |
| rd0_b | output | XLEN | Slot 0 second read data |
| rd1_a | output | XLEN | Slot 1 first read data |
| rd1_b | output | XLEN | Slot 1 second read data |
| wd0_idx | input | AW | Slot 0 destination (0 or 1 means no write) |
| wd0_data | input | XLEN | Slot 0 write data |
| wd1_idx | input | AW | Slot 1 destination (0 or 1 means no write) |
| wd1_data | input | XLEN | Slot 1 write data |

## Verification
Read data is due in the same cycle as the address and PC inputs. The bench therefore changes inputs just after a falling edge and samples a short delay later, with no rising edge in between. A write is due on the first rising edge after it is presented. The bench samples the targeted register and its neighbours after the following falling edge. For the same-cycle R9 check, it reads the register being written before that edge. Sweeps cover every register number on all four ports, after reset and after each write pattern, and the expected values come from a bench-side model updated in program order.

// File: rtl/rf_pkg.sv
package rf_pkg;

    // where a read port takes its value from
    typedef enum logic [1:0] {
        ZERO   = 2'd0,
        PCVAL  = 2'd1,
        STORED = 2'd2
    } rd_src_e;

    // write selector transitions
    typedef enum logic [1:0] {
        HOLD  = 2'd0,
        TAKE0 = 2'd1,
        TAKE1 = 2'd2
    } wr_sel_e;

    function automatic rd_src_e classify(input int unsigned regno);
        if (regno == 0)      return ZERO;
        else if (regno == 1) return PCVAL;
        else                 return STORED;
    endfunction

endpackage

// File: rtl/rf_read_port.sv
module rf_read_port
    import rf_pkg::*;
#(
    parameter int NREG = 32,
    parameter int XLEN = 32,
    parameter int PCW  = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic [AW-1:0]              addr,
    input  logic [PCW-1:0]             pc,
    input  logic [NREG-1:0][XLEN-1:0]  cells,
    output logic [XLEN-1:0]            data
);

    rd_src_e src;

    always_comb begin
        src = classify(int'(addr));
    end

    always_comb begin
        unique case (src)
            ZERO:    data = '0;
            PCVAL:   data = {{(XLEN-PCW){1'b0}}, pc};
            STORED:  data = cells[addr];
            default: data = '0;
        endcase
    end

endmodule

// File: rtl/rf_write_sel.sv
module rf_write_sel
    import rf_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int XLEN  = 32,
    parameter int REGNO = 2,
    localparam int AW   = $clog2(NREG)
) (
    input  logic [AW-1:0]   w0_idx,
    input  logic [XLEN-1:0] w0_data,
    input  logic [AW-1:0]   w1_idx,
    input  logic [XLEN-1:0] w1_data,
    output logic            load,
    output logic [XLEN-1:0] load_data
);

    localparam logic [AW-1:0] ME = AW'(REGNO);

    wr_sel_e sel;

    // slot 1 is later in program order, so it is tested first
    always_comb begin
        if (w1_idx == ME)      sel = TAKE1;
        else if (w0_idx == ME) sel = TAKE0;
        else                   sel = HOLD;
    end

    always_comb begin
        unique case (sel)
            HOLD:    begin load = 1'b0; load_data = '0;      end
            TAKE0:   begin load = 1'b1; load_data = w0_data; end
            TAKE1:   begin load = 1'b1; load_data = w1_data; end
            default: begin load = 1'b0; load_data = '0;      end
        endcase
    end

endmodule

// File: rtl/dual_rf.sv
module dual_rf
    import rf_pkg::*;
#(
    parameter int NREG = 32,
    parameter int XLEN = 32,
    parameter int PCW  = 16,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PCW-1:0]  pc0,
    input  logic [PCW-1:0]  pc1,
    input  logic [AW-1:0]   ra0_a,
    input  logic [AW-1:0]   ra0_b,
    input  logic [AW-1:0]   ra1_a,
    input  logic [AW-1:0]   ra1_b,
    output logic [XLEN-1:0] rd0_a,
    output logic [XLEN-1:0] rd0_b,
    output logic [XLEN-1:0] rd1_a,
    output logic [XLEN-1:0] rd1_b,
    input  logic [AW-1:0]   wd0_idx,
    input  logic [XLEN-1:0] wd0_data,
    input  logic [AW-1:0]   wd1_idx,
    input  logic [XLEN-1:0] wd1_data
);

    localparam int NPORT = 4;

    logic [NREG-1:0][XLEN-1:0] cells;

    // storage: registers 0 and 1 own no flops
    for (genvar r = 0; r < NREG; r++) begin : g_reg
        if (classify(r) != STORED) begin : g_none
            assign cells[r] = '0;
        end else begin : g_flop
            logic            load;
            logic [XLEN-1:0] load_data;
            logic [XLEN-1:0] q;

            rf_write_sel #(
                .NREG(NREG), .XLEN(XLEN), .REGNO(r)
            ) i_sel (
                .w0_idx   (wd0_idx),
                .w0_data  (wd0_data),
                .w1_idx   (wd1_idx),
                .w1_data  (wd1_data),
                .load     (load),
                .load_data(load_data)
            );

            always_ff @(posedge clk) begin
                if (!rst_n)     q <= '0;
                else if (load)  q <= load_data;
            end

            assign cells[r] = q;
        end
    end

    // read ports: 0,1 belong to slot 0; 2,3 to slot 1
    logic [NPORT-1:0][AW-1:0]   raddr;
    logic [NPORT-1:0][XLEN-1:0] rdata;
    logic [NPORT-1:0][PCW-1:0]  rpc;

    assign raddr = {ra1_b, ra1_a, ra0_b, ra0_a};
    assign rpc   = {pc1, pc1, pc0, pc0};

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        rf_read_port #(
            .NREG(NREG), .XLEN(XLEN), .PCW(PCW)
        ) i_rp (
            .addr (raddr[p]),
            .pc   (rpc[p]),
            .cells(cells),
            .data (rdata[p])
        );
    end

    assign rd0_a = rdata[0];
    assign rd0_b = rdata[1];
    assign rd1_a = rdata[2];
    assign rd1_b = rdata[3];

endmodule

// File: rtl/dual_rf_chk.sv
module dual_rf_chk #(
    parameter int AW   = 5,
    parameter int XLEN = 32,
    parameter int PCW  = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PCW-1:0]  pc0,
    input logic [PCW-1:0]  pc1,
    input logic [AW-1:0]   ra0_a,
    input logic [AW-1:0]   ra0_b,
    input logic [AW-1:0]   ra1_a,
    input logic [AW-1:0]   ra1_b,
    input logic [XLEN-1:0] rd0_a,
    input logic [XLEN-1:0] rd0_b,
    input logic [XLEN-1:0] rd1_a,
    input logic [XLEN-1:0] rd1_b,
    input logic [AW-1:0]   wd0_idx,
    input logic [XLEN-1:0] wd0_data,
    input logic [AW-1:0]   wd1_idx,
    input logic [XLEN-1:0] wd1_data
);

    localparam logic [AW-1:0] ONE = AW'(1);

    // R2
    p_zero_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ra0_a == '0) |-> (rd0_a == '0));

    p_zero_read_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ra1_b == '0) |-> (rd1_b == '0));

    // R3
    p_pc_slot0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ra0_b == ONE) |-> (rd0_b == {{(XLEN-PCW){1'b0}}, pc0}));

    p_pc_slot1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ra1_a == ONE) |-> (rd1_a == {{(XLEN-PCW){1'b0}}, pc1}));

    // R4
    p_write_seen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wd0_idx) > ONE && $past(wd1_idx) != $past(wd0_idx)
         && ra1_b == $past(wd0_idx)) |-> (rd1_b == $past(wd0_data)));

    // R7
    p_slot1_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wd1_idx) > ONE && ra0_a == $past(wd1_idx))
        |-> (rd0_a == $past(wd1_data)));

    // R5
    p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(ra0_b) && ra0_b > ONE
         && $past(wd0_idx) != ra0_b && $past(wd1_idx) != ra0_b)
        |-> $stable(rd0_b));

endmodule

bind dual_rf dual_rf_chk #(.AW(AW), .XLEN(XLEN), .PCW(PCW)) i_chk (.*);

// File: tb/test_dual_rf.sv
module test_dual_rf;

    localparam int NREG = 32;
    localparam int XLEN = 32;
    localparam int PCW  = 16;
    localparam int AW   = $clog2(NREG);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PCW-1:0]  pc0 = '0, pc1 = '0;
    logic [AW-1:0]   ra0_a = '0, ra0_b = '0, ra1_a = '0, ra1_b = '0;
    logic [XLEN-1:0] rd0_a, rd0_b, rd1_a, rd1_b;
    logic [AW-1:0]   wd0_idx = '0, wd1_idx = '0;
    logic [XLEN-1:0] wd0_data = '0, wd1_data = '0;

    int total = 0;
    int bad   = 0;
    logic [XLEN-1:0] model [NREG];

    always #10 clk = ~clk;  // 50 MHz

    dual_rf #(.NREG(NREG), .XLEN(XLEN), .PCW(PCW)) i_dual_rf (.*);

    function automatic logic [XLEN-1:0] expect_rd(input int r, input logic [PCW-1:0] pc);
        if (r == 0)      return '0;
        else if (r == 1) return {{(XLEN-PCW){1'b0}}, pc};
        else             return model[r];
    endfunction

    task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one register set per falling edge, sampled 2 ns later (R10)
    task automatic sweep(input string tag, input logic [PCW-1:0] p0, input logic [PCW-1:0] p1);
        for (int r = 0; r < NREG; r++) begin
            @(negedge clk);
            pc0 = p0; pc1 = p1;
            ra0_a = AW'(r);
            ra0_b = AW'((r + 1) % NREG);
            ra1_a = AW'((r + 5) % NREG);
            ra1_b = AW'((r + 9) % NREG);
            #2;
            check({tag, " rd0_a"}, rd0_a, expect_rd(r, p0));
            check({tag, " rd0_b"}, rd0_b, expect_rd((r + 1) % NREG, p0));
            check({tag, " rd1_a"}, rd1_a, expect_rd((r + 5) % NREG, p1));
            check({tag, " rd1_b"}, rd1_b, expect_rd((r + 9) % NREG, p1));
        end
    endtask

    // present a write pair, check same-cycle old value (R9), commit, update model
    task automatic write2(input int a0, input logic [XLEN-1:0] d0,
                          input int a1, input logic [XLEN-1:0] d1);
        @(negedge clk);
        wd0_idx = AW'(a0); wd0_data = d0;
        wd1_idx = AW'(a1); wd1_data = d1;
        ra0_a = AW'(a0); ra1_a = AW'(a1);
        #2;
        check("R9 old value slot0", rd0_a, expect_rd(a0, pc0));
        check("R9 old value slot1", rd1_a, expect_rd(a1, pc1));
        @(posedge clk);
        #1;
        if (a0 > 1) model[a0] = d0;
        if (a1 > 1) model[a1] = d1;  // later in program order
        wd0_idx = '0; wd1_idx = '0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int r = 0; r < NREG; r++) model[r] = '0;
        // dirty writes during reset must not survive (R1)
        wd0_idx = AW'(5); wd0_data = 32'hDEAD_BEEF;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        wd0_idx = '0;

        sweep("R1 reset R2 zero R3 pc", 16'h0000, 16'h0001);
        sweep("R3 pc per slot", 16'hFFFF, 16'h1234);

        // R4: every destination through port 0, then port 1
        for (int r = 0; r < NREG; r++)
            write2(r, 32'hA500_0000 ^ (r * 32'h0101_0101), 0, 32'hFFFF_FFFF);
        sweep("R4 R5 R6 port0 writes", 16'h8001, 16'h7FFE);
        for (int r = 0; r < NREG; r++)
            write2(0, 32'h1111_1111, r, ~(r * 32'h0003_0007));
        sweep("R4 R5 port1 writes", 16'h00F0, 16'h0F00);

        // R6: writes to register 1 from both slots
        write2(1, 32'hCAFE_0001, 1, 32'hCAFE_0002);
        sweep("R6 reg1 write dropped", 16'hABCD, 16'h4321);

        // R7: same destination on both ports
        for (int r = 2; r < NREG; r++)
            write2(r, 32'h0000_1000 + r, r, 32'h7000_0000 + r * 3);
        sweep("R7 slot1 wins", 16'h0002, 16'h0003);

        // R8: distinct destinations in one cycle
        for (int r = 2; r < NREG; r++)
            write2(r, 32'h5A5A_0000 | r, (r + 7) % NREG, 32'h00C3_0000 | (r << 4));
        sweep("R8 two writes", 16'h1357, 16'h2468);

        // R5: destination 0 on both ports
        write2(0, 32'hFFFF_FFFF, 0, 32'hEEEE_EEEE);
        sweep("R5 null dest", 16'h5555, 16'hAAAA);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule